// File: doc/BRIEF.md
# Vectored Interrupt Controller with Specific End-of-Interrupt

This block gathers a parameterised set of interrupt request lines (64 by default) into one interrupt output for a host. Each line has three configuration bits: a mask bit, a trigger-mode bit that selects level or edge, and a sense-class bit. Together these settle when the line counts as requesting. Among the lines that are requesting, unmasked and not in service, the lowest-numbered line wins.

The host samples the vector port in the same cycle that it pulses the read strobe. If an interrupt is being presented, the port gives the winning line's index and the read acknowledges that line. The line is then marked in service and any latched edge on it is consumed. If nothing is being presented, the port gives a passive-release flag instead, and the host must issue no end-of-interrupt for that read. Once the host has serviced the line, it writes the line's index back, and that write clears the in-service state of that one line only.

A one-word configuration write port loads the mask, trigger, class and mode registers. The mode register has one bit that turns off nesting. Line n maps to bit n in every per-line register.

Top module: `vic_top`

## Requirements
- R1: After synchronous reset every mask bit is 1, and the trigger, class, mode, latched-edge and in-service state is all zero, so irq_out is 0, vec_passive is 1 and vec_idx is 0.
- R2: A line whose mask bit is 1 never raises irq_out and is never reported. A mask bit of 0 lets the line take part.
- R3: A line whose trigger bit is 0 is edge-triggered. A low-to-high change, seen at a clock edge while the line is unmasked, latches a request. The request stays after the line falls and is cleared only when a vector read acknowledges the line.
- R4: A line whose trigger bit is 1 is level-sensitive and requests only while its level is active. If it deasserts before acknowledgement, the request is gone and a read returns passive release.
- R5: A class bit of 1 makes a level line active-low. A class bit of 0 makes it active-high. Edge lines trigger low-to-high in both classes.
- R6: Among the eligible lines (requesting, unmasked, not in service), the lowest index has priority.
- R7: When vec_rd is high while irq_out is 1, vec_idx is the winner, vec_passive is 0, and the line is in service from the next cycle. When irq_out is 0, the port gives vec_passive=1 and vec_idx=0 and the read changes nothing.
- R8: A pulse on eoi_we with index k clears the in-service bit of line k only, from the next cycle.
- R9: A line in service is not presented again. With nesting on, irq_out is 1 only if the winner's index is lower than every in-service index.
- R10: When mode bit 0 is 1, nesting is off, and irq_out is 1 whenever any eligible line exists.
- R11: cfg_we with cfg_sel set to 0 (mask), 1 (trigger), 2 (class) or 3 (mode, bit 0) loads cfg_data. The new value takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | LINES | Raw request lines, synchronous to clk |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 mask, 1 trigger, 2 class, 3 mode |
| cfg_data | input | LINES | Configuration write data |
| vec_rd | input | 1 | Vector read / acknowledge strobe |
| eoi_we | input | 1 | Specific end-of-interrupt strobe |
| eoi_vec | input | IDX_W | Line index to release from service |
| irq_out | output | 1 | Interrupt request to the host |
| vec_idx | output | IDX_W | Winning line index, 0 when passive |
| vec_passive | output | 1 | High when no interrupt is being presented |

## Verification
irq_out, vec_idx and vec_passive respond to a level line or a class change in the same cycle, because they are combinational from the line inputs and the held state. Configuration writes, acknowledges, end-of-interrupt writes and edge latching take effect one clock edge later. The bench drives inputs just after a rising edge. It checks the combinational results a moment later in that same cycle, and checks the registered effects only after the next rising edge. A behavioural model updated on every rising edge is compared with all three outputs on every falling edge.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    localparam int DEF_LINES = 64;

    typedef enum logic [1:0] {
        CFG_MASK  = 2'd0,
        CFG_TRIG  = 2'd1,
        CFG_CLASS = 2'd2,
        CFG_MODE  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic nest_off;
    } mode_t;
endpackage

// File: rtl/ivc_cfg.sv
module ivc_cfg #(
    parameter int N = ivc_pkg::DEF_LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [1:0]   sel,
    input  logic [N-1:0] data,
    output logic [N-1:0] mask,
    output logic [N-1:0] trig,
    output logic [N-1:0] cls,
    output ivc_pkg::mode_t mode
);
    import ivc_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '1;
            trig <= '0;
            cls  <= '0;
            mode <= '0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                CFG_MASK:  mask <= data;
                CFG_TRIG:  trig <= data;
                CFG_CLASS: cls  <= data;
                CFG_MODE:  mode.nest_off <= data[0];
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/ivc_sense.sv
module ivc_sense #(
    parameter int N = ivc_pkg::DEF_LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] trig,
    input  logic [N-1:0] cls,
    input  logic [N-1:0] ack,
    output logic [N-1:0] req
);
    logic [N-1:0] prev_q;
    logic [N-1:0] latch_q;

    for (genvar g = 0; g < N; g++) begin : g_line
        logic lvl_act;
        logic rise;
        assign lvl_act = cls[g] ? ~irq_in[g] : irq_in[g];
        assign rise    = irq_in[g] & ~prev_q[g];
        assign req[g]  = trig[g] ? lvl_act : latch_q[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q[g]  <= 1'b0;
                latch_q[g] <= 1'b0;
            end else begin
                prev_q[g]  <= irq_in[g];
                latch_q[g] <= ((latch_q[g] & ~ack[g]) | (rise & ~mask[g])) & ~trig[g];
            end
        end
    end
endmodule

// File: rtl/ivc_lowest.sv
module ivc_lowest #(
    parameter int N = ivc_pkg::DEF_LINES,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/vic_top.sv
module vic_top #(
    parameter int LINES = ivc_pkg::DEF_LINES,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] irq_in,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [LINES-1:0] cfg_data,
    input  logic             vec_rd,
    input  logic             eoi_we,
    input  logic [IDX_W-1:0] eoi_vec,
    output logic             irq_out,
    output logic [IDX_W-1:0] vec_idx,
    output logic             vec_passive
);
    import ivc_pkg::*;

    logic [LINES-1:0] mask_q, trig_q, cls_q;
    mode_t            mode_q;
    logic [LINES-1:0] req, elig, isr_q, ack_oh, eoi_oh;
    logic             win_found, isr_found;
    logic [IDX_W-1:0] win_idx, isr_low;
    logic             nest_off;

    assign nest_off = mode_q.nest_off;

    ivc_cfg #(.N(LINES)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .data(cfg_data),
        .mask(mask_q), .trig(trig_q), .cls(cls_q), .mode(mode_q)
    );

    ivc_sense #(.N(LINES)) u_sense (
        .clk(clk), .rst(rst), .irq_in(irq_in), .mask(mask_q), .trig(trig_q),
        .cls(cls_q), .ack(ack_oh), .req(req)
    );

    assign elig = req & ~mask_q & ~isr_q;

    ivc_lowest #(.N(LINES), .W(IDX_W)) u_win (
        .vec(elig), .found(win_found), .idx(win_idx)
    );

    ivc_lowest #(.N(LINES), .W(IDX_W)) u_isr (
        .vec(isr_q), .found(isr_found), .idx(isr_low)
    );

    assign irq_out     = win_found & (nest_off | ~isr_found | (win_idx < isr_low));
    assign vec_idx     = irq_out ? win_idx : '0;
    assign vec_passive = ~irq_out;

    always_comb begin
        ack_oh = '0;
        eoi_oh = '0;
        if (vec_rd && irq_out) ack_oh[win_idx] = 1'b1;
        if (eoi_we)            eoi_oh[eoi_vec] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) isr_q <= '0;
        else     isr_q <= (isr_q & ~eoi_oh) | ack_oh;
    end
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
    parameter int N = ivc_pkg::DEF_LINES,
    parameter int W = $clog2(N)
) (
    input logic         clk,
    input logic         rst,
    input logic         irq_out,
    input logic [W-1:0] vec_idx,
    input logic         vec_rd,
    input logic         eoi_we,
    input logic [W-1:0] eoi_vec,
    input logic [N-1:0] mask,
    input logic [N-1:0] isr,
    input logic         nest_off
);
    // R1: state after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        (!rst && $past(rst)) |-> (isr == '0 && !irq_out && mask == '1));

    // R2: a masked line is never reported
    a_r2_masked_silent: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> !mask[vec_idx]);

    // R7: an acknowledged line enters service
    a_r7_ack_sets_isr: assert property (@(posedge clk) disable iff (rst)
        (vec_rd && irq_out && !(eoi_we && eoi_vec == vec_idx)) |=> isr[$past(vec_idx)]);

    // R8: a specific end-of-interrupt releases its line
    a_r8_eoi_clears: assert property (@(posedge clk) disable iff (rst)
        (eoi_we && !(vec_rd && irq_out)) |=> !isr[$past(eoi_vec)]);

    // R9: with nesting on, no in-service line at or below the winner's index
    a_r9_nesting: assert property (@(posedge clk) disable iff (rst)
        (irq_out && !nest_off) |-> ((isr & ((N'(2) << vec_idx) - N'(1))) == '0));
endmodule

bind vic_top ivc_checker #(.N(LINES), .W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .irq_out(irq_out), .vec_idx(vec_idx),
    .vec_rd(vec_rd), .eoi_we(eoi_we), .eoi_vec(eoi_vec),
    .mask(mask_q), .isr(isr_q), .nest_off(nest_off)
);

// File: tb/vic_top_test.sv
module vic_top_test;
    localparam int L = 64;
    localparam int W = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [L-1:0] irq_in = '0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_sel = '0;
    logic [L-1:0] cfg_data = '0;
    logic         vec_rd = 1'b0;
    logic         eoi_we = 1'b0;
    logic [W-1:0] eoi_vec = '0;
    logic         irq_out;
    logic [W-1:0] vec_idx;
    logic         vec_passive;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    vic_top uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .vec_rd(vec_rd), .eoi_we(eoi_we), .eoi_vec(eoi_vec),
        .irq_out(irq_out), .vec_idx(vec_idx), .vec_passive(vec_passive)
    );

    // behavioural reference state
    bit [L-1:0] m_mask, m_trig, m_cls, m_latch, m_isr, m_prev;
    bit         m_nest_off;

    task automatic model_eval(output bit out, output int win);
        int lowisr;
        bit req;
        win = -1;
        lowisr = L;
        for (int i = L - 1; i >= 0; i--) begin
            if (m_isr[i]) lowisr = i;
            req = m_trig[i] ? (m_cls[i] ? !irq_in[i] : irq_in[i]) : m_latch[i];
            if (req && !m_mask[i] && !m_isr[i]) win = i;
        end
        out = (win >= 0) && (m_nest_off || win < lowisr);
    endtask

    always @(posedge clk) begin
        bit o;
        int w;
        if (rst) begin
            m_mask = '1; m_trig = '0; m_cls = '0; m_latch = '0;
            m_isr = '0; m_prev = '0; m_nest_off = 0;
        end else begin
            model_eval(o, w);
            for (int i = 0; i < L; i++) begin
                bit ack;
                ack = vec_rd && o && (w == i);
                m_latch[i] = ((m_latch[i] && !ack) || (irq_in[i] && !m_prev[i] && !m_mask[i])) && !m_trig[i];
                if (eoi_we && eoi_vec == W'(i)) m_isr[i] = 0;
                if (ack) m_isr[i] = 1;
            end
            m_prev = irq_in;
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: m_mask = cfg_data;
                    2'd1: m_trig = cfg_data;
                    2'd2: m_cls  = cfg_data;
                    default: m_nest_off = cfg_data[0];
                endcase
            end
        end
    end

    always @(negedge clk) begin
        bit o;
        int w;
        int ei;
        if (!rst && !done) begin
            model_eval(o, w);
            ei = o ? w : 0;
            checks++;
            if (irq_out !== o || vec_passive !== !o || vec_idx !== W'(ei)) begin
                errors++;
                $display("FAIL R6 R7 model compare: out=%0b idx=%0d passive=%0b expected out=%0b idx=%0d",
                         irq_out, vec_idx, vec_passive, o, ei);
            end
        end
    end

    task automatic chk(input string req, input bit out_e, input int idx_e);
        checks++;
        if (irq_out !== out_e || vec_passive !== !out_e || vec_idx !== W'(idx_e)) begin
            errors++;
            $display("FAIL %s: out=%0b idx=%0d passive=%0b expected out=%0b idx=%0d",
                     req, irq_out, vec_idx, vec_passive, out_e, idx_e);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg(input int sel, input logic [L-1:0] d);
        cfg_we = 1; cfg_sel = 2'(sel); cfg_data = d;
        tick();
        cfg_we = 0;
        #1;
    endtask

    task automatic rd();
        vec_rd = 1;
        tick();
        vec_rd = 0;
        #1;
    endtask

    task automatic eoi(input int k);
        eoi_we = 1; eoi_vec = W'(k);
        tick();
        eoi_we = 0;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    localparam logic [L-1:0] B3 = L'(1) << 3, B5 = L'(1) << 5,
                             B10 = L'(1) << 10, B20 = L'(1) << 20;

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        #1;
        chk("R1 reset state", 0, 0);

        cfg(1, B3 | B5 | B20);
        cfg(2, B20);
        irq_in[5] = 1; irq_in[20] = 1;
        #1 chk("R2 masked level line", 0, 0);
        cfg(0, ~B5);
        chk("R11 mask write unmasks line 5", 1, 5);
        irq_in[3] = 1;
        #1 chk("R2 line 3 still masked", 1, 5);
        cfg(0, ~(B3 | B5));
        chk("R6 lowest index wins", 1, 3);

        vec_rd = 1;
        #1 chk("R7 read returns winner", 1, 3);
        tick();
        vec_rd = 0;
        #1 chk("R9 line 5 blocked by line 3 in service", 0, 0);

        cfg(3, L'(1));
        chk("R10 nesting off presents line 5", 1, 5);
        cfg(3, '0);
        chk("R10 nesting back on", 0, 0);

        eoi(3);
        chk("R8 eoi releases line 3", 1, 3);

        irq_in[3] = 0; irq_in[5] = 0;
        vec_rd = 1;
        #1 chk("R4 level dropped gives passive read", 0, 0);
        tick();
        vec_rd = 0;
        #1;

        cfg(0, ~(B3 | B5 | B20));
        chk("R5 active-low line held high is idle", 0, 0);
        irq_in[20] = 0;
        #1 chk("R5 active-low line driven low requests", 1, 20);
        irq_in[20] = 1;
        #1;

        cfg(0, ~(B3 | B5 | B20 | B10));
        irq_in[10] = 1;
        tick();
        irq_in[10] = 0;
        #1 chk("R3 edge latched after line falls", 1, 10);
        rd();
        chk("R3 acknowledged edge line in service", 0, 0);
        eoi(10);
        chk("R3 latch consumed by acknowledge", 0, 0);

        for (int n = 0; n < 400; n++) begin
            irq_in[15:0] = 16'($urandom);
            vec_rd  = ($urandom % 3) == 0;
            eoi_we  = ($urandom % 3) == 0;
            eoi_vec = W'($urandom % 16);
            cfg_we  = ($urandom % 16) == 0;
            cfg_sel = 2'($urandom % 4);
            cfg_data = {48'hFFFF_FFFF_FFFF, 16'($urandom)};
            tick();
        end
        vec_rd = 0; eoi_we = 0; cfg_we = 0;
        tick();

        rst = 1;
        tick();
        rst = 0;
        #1 chk("R1 second reset clears state", 0, 0);
        tick();
        finish_run();
    end
endmodule